// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer with Full-Duty Override

This block is a 16-bit up-counter with a power-of-two prescaler and a programmable wrap value. Two channels share the counter. Each channel either captures the count when its input pin changes, or compares the count against a stored value and drives its output pin. In compare mode the output can toggle on each match, or it can form a PWM wave. A per-channel request forces that PWM wave to full duty, and the request takes effect one period late.

Software reaches every register through a plain 8-bit port with a combinational read. All 16-bit quantities are moved one byte at a time, and holding logic keeps each pair of byte accesses coherent. The register port is control traffic, not a stream, so it has no valid/ready pair and no back-pressure. A write or a read strobe is acted on at the clock edge that ends its cycle. `bus_rdata` is valid during the cycle in which `bus_rd` is high.

Register addresses: CTRL 0, count high byte 1, count low byte 2, wrap high byte 3, wrap low byte 4. Channel c has its configuration at 8+4c, its value high byte at 9+4c and its value low byte at 10+4c.

Top module: `tmr_pwm_timer`

## Requirements
- R1: After reset the following hold. CTRL reads 0x01, meaning stopped (bit 0 = 1) with prescale field bits [4:2] = 0. The count is 0. Every `ch_pin_out` is 0 and every `ch_flag` is 0.
- R2: With CTRL bit 0 clear, the count advances by one on each prescaler tick. When the count equals the wrap value it returns to 0 on the next tick. A wrap value of 0 selects the full 16-bit range.
- R3: CTRL field [4:2] = p gives one tick every 2^p clock cycles. Writing 1 to CTRL bit 1 (it reads 0) clears the count and the prescaler phase at that edge.
- R4: While CTRL bit 0 is 1 the count does not change.
- R5: Reading the count low byte (address 2) holds the high byte as it was at that read. The next read of address 1 returns the held byte. Reads of address 1 after that return the live high byte.
- R6: Configuration bit 0 = 0 selects capture. A rising edge on `ch_pin_in`, or a falling edge when bit 3 = 1, passes a two-flop synchroniser. The count present at the third edge after the pin change is then stored as the channel value, and the channel flag (configuration bit 7, also `ch_flag`) is set.
- R7: In capture mode, reading the value high byte blocks any further capture until the value low byte is read.
- R8: Configuration bit 0 = 1 with bit 1 = 0 selects compare-toggle. On the tick where the count equals the value, the output pin inverts and the flag is set.
- R9: In compare mode, writing the value high byte stops all matches. Matching resumes when the low byte is written, and that write loads the full 16-bit value.
- R10: Configuration bits 0 and 1 both set select PWM. The output goes to 1 on the tick that wraps the count and to 0 on the tick that matches the value.
- R11: Configuration bit 2 requests full duty in PWM mode. The request is sampled only at a wrap. While the sampled request is set, a match does not clear the output. Setting or clearing bit 2 therefore changes the wave only from the next period on.
- R12: The flag is cleared only by a configuration write with bit 7 = 0 that follows a configuration read which saw the flag set. A write without that read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (starts the side effects of a read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ch_pin_in | input | 2 | Capture input pin per channel |
| ch_pin_out | output | 2 | Compare/PWM output pin per channel |
| ch_flag | output | 2 | Event flag per channel |

## Verification
The bench builds the block with its defaults: an 8-bit data port, two channels and a 3-bit prescale field.

It programs a wrap value of 9, which keeps several wraps, matches and PWM periods within a few dozen cycles. That makes every cycle of the late-acting full-duty override easy to predict. With the wrap value at 0 the count runs freely past 0xFF, which shows the held high byte on a split read. A prescale field of 2 checks the tick spacing and the clearing of the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {CH_CAPTURE = 1'b0, CH_COMPARE = 1'b1} ch_mode_e;

  typedef struct packed {
    logic     edge_fall;
    logic     max_req;
    logic     pwm_en;
    ch_mode_e mode;
  } ch_cfg_t;

  localparam int unsigned ADR_CTRL      = 0;
  localparam int unsigned ADR_CNT_HI    = 1;
  localparam int unsigned ADR_CNT_LO    = 2;
  localparam int unsigned ADR_MOD_HI    = 3;
  localparam int unsigned ADR_MOD_LO    = 4;
  localparam int unsigned ADR_CH_BASE   = 8;
  localparam int unsigned ADR_CH_STRIDE = 4;
  localparam int unsigned CH_OFS_CFG    = 0;
  localparam int unsigned CH_OFS_HI     = 1;
  localparam int unsigned CH_OFS_LO     = 2;

  localparam int unsigned CTRL_STOP_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;
  localparam int unsigned CTRL_PS_LSB   = 2;
  localparam int unsigned CFG_FLAG_BIT  = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int unsigned PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] phase_q;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick = run && ((phase_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (clr) phase_q <= '0;
    else if (run) phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic [CNT_W-1:0]  wrap_val,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf,
  output logic [DATA_W-1:0] hi_view
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  top;
  logic [DATA_W-1:0] snap_q;
  logic              snap_vld_q;

  assign top     = (wrap_val == '0) ? '1 : wrap_val;
  assign ovf     = tick && (cnt_q == top);
  assign cnt     = cnt_q;
  assign hi_view = snap_vld_q ? snap_q : cnt_q[CNT_W-1 -: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (ovf)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
    end else if (rd_lo) begin
      snap_q     <= cnt_q[CNT_W-1 -: DATA_W];
      snap_vld_q <= 1'b1;
    end else if (rd_hi) begin
      snap_vld_q <= 1'b0;
    end
  end

  AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> (cnt_q == '0)); // R2
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_vld_q && !rd_lo) |=> (snap_q == $past(snap_q))); // R5
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick,
  input  logic              ovf,
  input  logic              pin_in,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic              hi_rd,
  input  logic              lo_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic              pin_out,
  output logic              flag,
  output logic [DATA_W-1:0] cfg_view,
  output logic [DATA_W-1:0] hi_view,
  output logic [DATA_W-1:0] lo_view
);
  ch_cfg_t           cfg_q;
  ch_cfg_t           cfg_nx;
  logic [2:0]        sync_q;
  logic [CNT_W-1:0]  val_q;
  logic [DATA_W-1:0] hbuf_q;
  logic              lock_q, inhib_q, max_eff_q, out_q, flag_q, arm_q;
  logic              is_cmp, rise, fall, cap_evt, cmp_evt;

  assign cfg_nx  = ch_cfg_t'(wdata[3:0]);
  assign is_cmp  = (cfg_q.mode == CH_COMPARE);
  assign rise    = sync_q[1] & ~sync_q[2];
  assign fall    = ~sync_q[1] & sync_q[2];
  assign cap_evt = !is_cmp && !lock_q && (cfg_q.edge_fall ? fall : rise);
  assign cmp_evt = is_cmp && !inhib_q && tick && (cnt == val_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], pin_in};
      if (cfg_wr) cfg_q <= cfg_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      inhib_q <= 1'b0;
      hbuf_q  <= '0;
      val_q   <= '0;
    end else begin
      if (cfg_wr && cfg_nx.mode == CH_COMPARE) lock_q <= 1'b0;
      else if (lo_rd)                          lock_q <= 1'b0;
      else if (hi_rd && !is_cmp)               lock_q <= 1'b1;

      if (cfg_wr && cfg_nx.mode == CH_CAPTURE) inhib_q <= 1'b0;
      else if (lo_wr && is_cmp)                inhib_q <= 1'b0;
      else if (hi_wr && is_cmp)                inhib_q <= 1'b1;

      if (hi_wr && is_cmp) hbuf_q <= wdata;

      if (cap_evt)              val_q <= cnt;
      else if (lo_wr && is_cmp) val_q <= {hbuf_q, wdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_eff_q <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      if (ovf) max_eff_q <= cfg_q.max_req;
      if (!is_cmp) begin
        out_q <= 1'b0;
      end else if (cfg_q.pwm_en) begin
        if (ovf)                        out_q <= 1'b1;
        else if (cmp_evt && !max_eff_q) out_q <= 1'b0;
      end else if (cmp_evt) begin
        out_q <= ~out_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (cfg_wr)                arm_q <= 1'b0;
      else if (cfg_rd && flag_q) arm_q <= 1'b1;

      if (cap_evt || cmp_evt)                              flag_q <= 1'b1;
      else if (cfg_wr && arm_q && !wdata[CFG_FLAG_BIT])    flag_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_view               = '0;
    cfg_view[3:0]          = cfg_q;
    cfg_view[CFG_FLAG_BIT] = flag_q;
  end

  assign hi_view = val_q[CNT_W-1 -: DATA_W];
  assign lo_view = val_q[DATA_W-1:0];
  assign pin_out = out_q;
  assign flag    = flag_q;

  AST_CAP_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !is_cmp && !cfg_wr) |=> (val_q == $past(val_q))); // R7
  AST_OC_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (inhib_q && is_cmp && !cfg_q.pwm_en && !cfg_wr) |=> $stable(pin_out)); // R9
  AST_MAX_STAY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (max_eff_q && pin_out && is_cmp && cfg_q.pwm_en && !cfg_wr) |=> pin_out); // R11
  AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(arm_q)); // R12
endmodule

// File: rtl/tmr_pwm_timer.sv
module tmr_pwm_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned NCH    = 2,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ch_pin_in,
  output logic [NCH-1:0]    ch_pin_out,
  output logic [NCH-1:0]    ch_flag
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic              stop_q;
  logic [PS_W-1:0]   ps_q;
  logic [CNT_W-1:0]  wrap_q;
  logic              ctr_clr, tick, ovf;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cnt_hi_view;
  logic              ctrl_wr;

  logic [DATA_W-1:0] ch_cfg_v [NCH];
  logic [DATA_W-1:0] ch_hi_v  [NCH];
  logic [DATA_W-1:0] ch_lo_v  [NCH];

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign ctr_clr = ctrl_wr && bus_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      ps_q   <= '0;
      wrap_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(ADR_CTRL)) begin
        stop_q <= bus_wdata[CTRL_STOP_BIT];
        ps_q   <= bus_wdata[CTRL_PS_LSB +: PS_W];
      end
      if (bus_addr == ADDR_W'(ADR_MOD_HI)) wrap_q[CNT_W-1 -: DATA_W] <= bus_wdata;
      if (bus_addr == ADDR_W'(ADR_MOD_LO)) wrap_q[DATA_W-1:0]        <= bus_wdata;
    end
  end

  tmr_prescaler #(.PS_W(PS_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(!stop_q), .clr(ctr_clr), .sel(ps_q), .tick(tick)
  );

  tmr_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(ctr_clr), .wrap_val(wrap_q),
    .rd_lo(bus_rd && (bus_addr == ADDR_W'(ADR_CNT_LO))),
    .rd_hi(bus_rd && (bus_addr == ADDR_W'(ADR_CNT_HI))),
    .cnt(cnt), .ovf(ovf), .hi_view(cnt_hi_view)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = ADR_CH_BASE + ADR_CH_STRIDE * c;
    logic sel_cfg, sel_hi, sel_lo;
    assign sel_cfg = (bus_addr == ADDR_W'(BASE + CH_OFS_CFG));
    assign sel_hi  = (bus_addr == ADDR_W'(BASE + CH_OFS_HI));
    assign sel_lo  = (bus_addr == ADDR_W'(BASE + CH_OFS_LO));

    tmr_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(tick), .ovf(ovf),
      .pin_in(ch_pin_in[c]),
      .cfg_wr(bus_wr && sel_cfg), .cfg_rd(bus_rd && sel_cfg),
      .hi_wr(bus_wr && sel_hi),   .lo_wr(bus_wr && sel_lo),
      .hi_rd(bus_rd && sel_hi),   .lo_rd(bus_rd && sel_lo),
      .wdata(bus_wdata),
      .pin_out(ch_pin_out[c]), .flag(ch_flag[c]),
      .cfg_view(ch_cfg_v[c]), .hi_view(ch_hi_v[c]), .lo_view(ch_lo_v[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) begin
      bus_rdata[CTRL_STOP_BIT]            = stop_q;
      bus_rdata[CTRL_PS_LSB +: PS_W]      = ps_q;
    end
    if (bus_addr == ADDR_W'(ADR_CNT_HI)) bus_rdata = cnt_hi_view;
    if (bus_addr == ADDR_W'(ADR_CNT_LO)) bus_rdata = cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(ADR_MOD_HI)) bus_rdata = wrap_q[CNT_W-1 -: DATA_W];
    if (bus_addr == ADDR_W'(ADR_MOD_LO)) bus_rdata = wrap_q[DATA_W-1:0];
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(ADR_CH_BASE + ADR_CH_STRIDE * c + CH_OFS_CFG)) bus_rdata = ch_cfg_v[c];
      if (bus_addr == ADDR_W'(ADR_CH_BASE + ADR_CH_STRIDE * c + CH_OFS_HI))  bus_rdata = ch_hi_v[c];
      if (bus_addr == ADDR_W'(ADR_CH_BASE + ADR_CH_STRIDE * c + CH_OFS_LO))  bus_rdata = ch_lo_v[c];
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !ctr_clr) |=> $stable(cnt)); // R4
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !tick); // R3
endmodule

// File: tb/tb_tmr_pwm_timer.sv
module tb_tmr_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] ch_pin_in = '0;
  logic [1:0] ch_pin_out;
  logic [1:0] ch_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_pin_in(ch_pin_in),
    .ch_pin_out(ch_pin_out), .ch_flag(ch_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 5'(a); bus_rd = 1'b1;
    #2 d = int'(bus_rdata);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    rd(0, v);  chk("R1 ctrl", v, 8'h01);
    rd(2, v);  chk("R1 count", v, 0);
    chk("R1 pins", int'(ch_pin_out), 0);
    chk("R1 flags", int'(ch_flag), 0);
  endtask

  task automatic t_wrap();
    int v;
    wr(3, 0); wr(4, 9);
    wr(0, 8'h02);
    repeat (6) @(posedge clk); #1;
    rd(2, v); chk("R2 count before wrap", v, 6);
    repeat (6) @(posedge clk); #1;
    rd(2, v); chk("R2 count after wrap", v, 3);
  endtask

  task automatic t_stop();
    int a, b;
    wr(0, 8'h01);
    rd(2, a);
    repeat (5) @(posedge clk); #1;
    rd(2, b); chk("R4 frozen", b, a);
  endtask

  task automatic t_prescale();
    int v;
    wr(4, 0);
    wr(0, 8'h0A);
    repeat (20) @(posedge clk); #1;
    rd(2, v); chk("R3 divide by 4", v, 5);
    wr(0, 8'h0A);
    rd(2, v); chk("R3 clear", v, 0);
  endtask

  task automatic t_split_read();
    int v;
    wr(0, 8'h02);
    repeat (253) @(posedge clk); #1;
    rd(2, v); chk("R5 low byte", v, 8'hFD);
    repeat (10) @(posedge clk); #1;
    rd(1, v); chk("R5 held high", v, 8'h00);
    rd(1, v); chk("R5 live high", v, 8'h01);
  endtask

  task automatic t_capture();
    int v, first;
    wr(0, 8'h01);
    wr(8, 8'h00);
    wr(0, 8'h02);
    repeat (9) @(posedge clk); #1;
    ch_pin_in[0] = 1'b1;
    repeat (4) @(posedge clk); #1;
    rd(10, v); chk("R6 captured value", v, 11);
    first = v;
    chk("R6 flag", int'(ch_flag[0]), 1);
    rd(9, v); chk("R6 captured high", v, 0);
    ch_pin_in[0] = 1'b0; repeat (3) @(posedge clk); #1;
    ch_pin_in[0] = 1'b1; repeat (5) @(posedge clk); #1;
    rd(10, v); chk("R7 locked value kept", v, first);
    ch_pin_in[0] = 1'b0; repeat (3) @(posedge clk); #1;
    ch_pin_in[0] = 1'b1; repeat (5) @(posedge clk); #1;
    rd(10, v); chk("R7 capture resumes", int'(v != first), 1);
    wr(8, 8'h00);
    chk("R12 flag kept without read", int'(ch_flag[0]), 1);
    rd(8, v); chk("R12 flag bit visible", v, 8'h80);
    wr(8, 8'h00);
    chk("R12 flag cleared", int'(ch_flag[0]), 0);
  endtask

  task automatic t_compare();
    int changes;
    logic p;
    wr(0, 8'h01);
    wr(4, 9);
    wr(12, 8'h01); wr(13, 0); wr(14, 5);
    wr(0, 8'h02);
    repeat (5) @(posedge clk); #1;
    chk("R8 before match", int'(ch_pin_out[1]), 0);
    @(posedge clk); #1;
    chk("R8 toggled high", int'(ch_pin_out[1]), 1);
    chk("R8 flag", int'(ch_flag[1]), 1);
    repeat (9) @(posedge clk); #1;
    chk("R8 held", int'(ch_pin_out[1]), 1);
    @(posedge clk); #1;
    chk("R8 toggled low", int'(ch_pin_out[1]), 0);
    wr(13, 0);
    p = ch_pin_out[1];
    repeat (25) @(posedge clk); #1;
    chk("R9 no match while inhibited", int'(ch_pin_out[1]), int'(p));
    wr(14, 5);
    changes = 0;
    for (int i = 0; i < 25; i++) begin
      p = ch_pin_out[1];
      @(posedge clk); #1;
      if (ch_pin_out[1] != p) changes++;
    end
    chk("R9 matching resumes", int'(changes > 0), 1);
  endtask

  task automatic t_pwm();
    wr(0, 8'h01);
    wr(8, 8'h03); wr(9, 0); wr(10, 3);
    wr(0, 8'h02);
    repeat (3) @(posedge clk); #1;
    chk("R10 low before first wrap", int'(ch_pin_out[0]), 0);
    repeat (9) @(posedge clk); #1;
    chk("R10 high after wrap", int'(ch_pin_out[0]), 1);
    repeat (3) @(posedge clk); #1;
    chk("R10 low after match", int'(ch_pin_out[0]), 0);
    repeat (6) @(posedge clk); #1;
    chk("R10 high next period", int'(ch_pin_out[0]), 1);
  endtask

  task automatic t_max();
    wr(0, 8'h01);
    wr(8, 8'h07);
    wr(0, 8'h02);
    repeat (5) @(posedge clk); #1;
    chk("R11 not yet in force", int'(ch_pin_out[0]), 0);
    repeat (10) @(posedge clk); #1;
    chk("R11 full duty past match", int'(ch_pin_out[0]), 1);
    repeat (10) @(posedge clk); #1;
    chk("R11 full duty second period", int'(ch_pin_out[0]), 1);
    wr(8, 8'h03);
    repeat (2) @(posedge clk); #1;
    chk("R11 stays until next period", int'(ch_pin_out[0]), 1);
    repeat (7) @(posedge clk); #1;
    chk("R11 released", int'(ch_pin_out[0]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_wrap();
    t_stop();
    t_prescale();
    t_split_read();
    t_capture();
    t_compare();
    t_pwm();
    t_max();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule